// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block decides which external interrupt level, if any, a processor should take next. Each cycle it combines a vector of level requests from outside the core with the software-interrupt bits. The two timer-match bits do not merge at their own positions. Either one of them instead raises level 14. The block then looks only at the levels strictly above the processor's current interrupt level and picks the highest one. That level becomes an external-interrupt trap type, `TT_BASE | level`, which is 0x41 to 0x4F with the default base of 0x40.

The choice is held in registers and re-evaluated on every clock edge. The registered request line and trap type therefore follow any input change one clock later. A pending vector interrupt freezes the resolver, because it outranks every external level. Inside a nested trap, a request is not raised when the trap already being serviced is a higher-numbered external interrupt. Clearing the global enable, or leaving nothing pending above the current level, withdraws the request.

Top module: `pil_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_req` and `trap_type` become 0; whenever `irq_req` is 0, `trap_type` is 0.
- R2: Software-interrupt bits 0..15, other than the two timer-match positions (bit 0 and bit 16), take part in the selection exactly like the external level bit with the same index.
- R3: A set timer-match bit (`soft_int[0]` or `soft_int[16]`) makes level 14 pending. It does not make its own bit position pending.
- R4: With `int_en` high, `vec_busy` low and no nesting block, the clock edge after the inputs settle gives `irq_req`=1 and `trap_type` = 0x40 | L. L is the highest pending level strictly above `cur_lvl`, and a new higher level replaces the old choice.
- R5: When no pending level lies above `cur_lvl`, which is always the case with `cur_lvl`=15, the next edge gives `irq_req`=0 and `trap_type`=0.
- R6: While `vec_busy` is high, `irq_req` and `trap_type` keep their values at every edge, whatever the other inputs do.
- R7: With `int_en` low and `vec_busy` low, the next edge gives `irq_req`=0 and `trap_type`=0.
- R8: When `tl_nz` is high, and `cur_tt` has its upper bits (8..4) equal to 0x40's and is greater than the candidate trap type, the outputs keep their values.
- R9: No suppression takes place when `tl_nz` is low, when `cur_tt` lies outside the external-interrupt group, or when `cur_tt` is not greater than the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External interrupt level requests, bit i = level i |
| soft_int | input | 17 | Software-interrupt bits; bit 0 and bit 16 are timer-match bits |
| cur_lvl | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| tl_nz | input | 1 | Trap level is nonzero |
| cur_tt | input | 9 | Trap type of the trap currently being serviced |
| vec_busy | input | 1 | A vector interrupt is pending and outranks all levels |
| irq_req | output | 1 | Registered interrupt request |
| trap_type | output | 9 | Registered selected trap type (0 when no request) |

## Verification
The hardest state to reach is the nested-trap suppression. It needs a nonzero trap level, a serviced trap type inside the external group, and a candidate level strictly below it, all at once. The state becomes observable only when a request is already latched, because suppression otherwise looks the same as nothing happening. The stimulus first latches level 9. It then presents level 6 while the serviced type is 0x4A and checks that 0x49 survives. Next it moves the serviced type outside the group, and then drops the trap level, to show that the lower level is taken in each case. The vector-busy hold is exercised in the same way, with inputs that would otherwise both raise a higher level and withdraw the request.

// File: rtl/pil_res_pkg.sv
package pil_res_pkg;

   // Next-state action chosen by the resolver each cycle
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_RAISE = 2'd2
   } pil_act_e;

endpackage

// File: rtl/pil_pend_merge.sv
module pil_pend_merge #(
   parameter int LVL_N     = 16,
   parameter int SOFT_W    = 17,
   parameter int TICK_BIT  = 0,
   parameter int STICK_BIT = 16,
   parameter int FOLD_LVL  = 14
) (
   input  logic [LVL_N-1:0]  ext_lvl,
   input  logic [SOFT_W-1:0] soft_int,
   output logic [LVL_N-1:0]  pend
);

   logic timer_hit;
   assign timer_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];

   for (genvar g = 0; g < LVL_N; g++) begin : g_bit
      logic soft_part;
      if (g < SOFT_W && g != TICK_BIT && g != STICK_BIT) begin : g_soft
         assign soft_part = soft_int[g];
      end else begin : g_nosoft
         assign soft_part = 1'b0;
      end
      if (g == FOLD_LVL) begin : g_fold
         assign pend[g] = ext_lvl[g] | soft_part | timer_hit;
      end else begin : g_plain
         assign pend[g] = ext_lvl[g] | soft_part;
      end
   end

endmodule

// File: rtl/pil_above_mask.sv
module pil_above_mask #(
   parameter int LVL_N = 16,
   parameter int LVL_W = 4
) (
   input  logic [LVL_W-1:0] cur_lvl,
   output logic [LVL_N-1:0] above
);

   for (genvar g = 0; g < LVL_N; g++) begin : g_cmp
      assign above[g] = (cur_lvl < LVL_W'(g));
   end

endmodule

// File: rtl/pil_prio_scan.sv
module pil_prio_scan #(
   parameter int LVL_N     = 16,
   parameter int LVL_W     = 4,
   parameter bit SCAN_TREE = 1'b1
) (
   input  logic [LVL_N-1:0] req,
   output logic             found,
   output logic [LVL_W-1:0] idx
);

   assign found = |req;

   if (SCAN_TREE) begin : g_onehot
      logic [LVL_N-1:0] top_oh;
      for (genvar g = 0; g < LVL_N; g++) begin : g_iso
         if (g == LVL_N-1) begin : g_msb
            assign top_oh[g] = req[g];
         end else begin : g_lower
            assign top_oh[g] = req[g] & ~(|req[LVL_N-1:g+1]);
         end
      end
      always_comb begin
         idx = '0;
         for (int i = 0; i < LVL_N; i++) begin
            if (top_oh[i]) idx = idx | LVL_W'(i);
         end
      end
   end else begin : g_linear
      always_comb begin
         idx = '0;
         for (int i = 0; i < LVL_N; i++) begin
            if (req[i]) idx = LVL_W'(i);
         end
      end
   end

   // R4: the chosen index is a set bit and nothing above it is set
   always_comb begin
      if (found) begin
         scan_pick_chk: assert (req[idx] && ((req >> idx) == 1));
      end
   end

endmodule

// File: rtl/pil_resolver.sv
module pil_resolver #(
   parameter int LVL_N     = 16,
   parameter int TT_W      = 9,
   parameter int TT_BASE   = 64,
   parameter int SOFT_W    = 17,
   parameter int TICK_BIT  = 0,
   parameter int STICK_BIT = 16,
   parameter int FOLD_LVL  = 14,
   parameter bit SCAN_TREE = 1'b1,
   localparam int LVL_W    = $clog2(LVL_N)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LVL_N-1:0]  ext_lvl,
   input  logic [SOFT_W-1:0] soft_int,
   input  logic [LVL_W-1:0]  cur_lvl,
   input  logic              int_en,
   input  logic              tl_nz,
   input  logic [TT_W-1:0]   cur_tt,
   input  logic              vec_busy,
   output logic              irq_req,
   output logic [TT_W-1:0]   trap_type
);

   import pil_res_pkg::*;

   localparam logic [TT_W-1:0]       BASE_V  = TT_W'(TT_BASE);
   localparam logic [TT_W-LVL_W-1:0] BASE_HI = BASE_V[TT_W-1:LVL_W];

   // elaboration-time parameter checks
   if ((1 << LVL_W) != LVL_N) begin : g_chk_pow2
      $error("LVL_N must be a power of two");
   end
   if ((TT_BASE % LVL_N) != 0) begin : g_chk_align
      $error("TT_BASE must be aligned to LVL_N");
   end
   if (TT_BASE + LVL_N > (1 << TT_W)) begin : g_chk_fit
      $error("trap types do not fit in TT_W bits");
   end
   if (FOLD_LVL >= LVL_N || FOLD_LVL < 1) begin : g_chk_fold
      $error("FOLD_LVL out of range");
   end
   if (TICK_BIT >= SOFT_W || STICK_BIT >= SOFT_W || TICK_BIT == STICK_BIT) begin : g_chk_tmr
      $error("timer-match bit positions invalid");
   end

   logic [LVL_N-1:0] pend;
   logic [LVL_N-1:0] above;
   logic [LVL_N-1:0] masked;
   logic             found;
   logic [LVL_W-1:0] idx;
   logic [TT_W-1:0]  cand_tt;
   logic             grp_hit;
   logic             nest_block;
   pil_act_e         act;
   logic             req_q;
   logic [TT_W-1:0]  tt_q;

   pil_pend_merge #(
      .LVL_N(LVL_N), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
      .STICK_BIT(STICK_BIT), .FOLD_LVL(FOLD_LVL)
   ) u_merge (
      .ext_lvl (ext_lvl),
      .soft_int(soft_int),
      .pend    (pend)
   );

   pil_above_mask #(.LVL_N(LVL_N), .LVL_W(LVL_W)) u_mask (
      .cur_lvl(cur_lvl),
      .above  (above)
   );

   assign masked = pend & above;

   pil_prio_scan #(.LVL_N(LVL_N), .LVL_W(LVL_W), .SCAN_TREE(SCAN_TREE)) u_scan (
      .req  (masked),
      .found(found),
      .idx  (idx)
   );

   assign cand_tt    = {BASE_HI, idx};
   assign grp_hit    = (cur_tt[TT_W-1:LVL_W] == BASE_HI);
   assign nest_block = tl_nz && grp_hit && (cur_tt > cand_tt);

   always_comb begin
      if (vec_busy)              act = ACT_HOLD;
      else if (!found)           act = ACT_CLEAR;
      else if (!int_en)          act = ACT_CLEAR;
      else if (nest_block)       act = ACT_HOLD;
      else if (cand_tt != tt_q)  act = ACT_RAISE;
      else                       act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q <= 1'b0;
         tt_q  <= '0;
      end else begin
         case (act)
            ACT_CLEAR: begin
               req_q <= 1'b0;
               tt_q  <= '0;
            end
            ACT_RAISE: begin
               req_q <= 1'b1;
               tt_q  <= cand_tt;
            end
            default: begin
               req_q <= req_q;
               tt_q  <= tt_q;
            end
         endcase
      end
   end

   assign irq_req   = req_q;
   assign trap_type = tt_q;

   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_req |-> (trap_type == '0));

   // R4
   tt_group_chk: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> (trap_type[TT_W-1:LVL_W] == BASE_HI && trap_type[LVL_W-1:0] != '0));

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      vec_busy |=> ($stable(irq_req) && $stable(trap_type)));

   // R7
   dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!int_en && !vec_busy) |=> !irq_req);

   // R5
   top_lvl_chk: assert property (@(posedge clk) disable iff (rst)
      (!vec_busy && cur_lvl == '1) |=> (!irq_req && trap_type == '0));

   // R8
   nest_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!vec_busy && int_en && found && nest_block) |=> $stable(trap_type));

endmodule

// File: tb/pil_resolver_tb.sv
module pil_resolver_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] ext_lvl = '0;
   logic [16:0] soft_int = '0;
   logic [3:0]  cur_lvl = '0;
   logic        int_en = 1'b0;
   logic        tl_nz = 1'b0;
   logic [8:0]  cur_tt = '0;
   logic        vec_busy = 1'b0;
   logic        irq_req;
   logic [8:0]  trap_type;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   logic       q_req[$];
   logic [8:0] q_tt[$];
   string      q_tag[$];

   always #10 clk = ~clk;   // 50 MHz

   pil_resolver u_dut (
      .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
      .cur_lvl(cur_lvl), .int_en(int_en), .tl_nz(tl_nz), .cur_tt(cur_tt),
      .vec_busy(vec_busy), .irq_req(irq_req), .trap_type(trap_type)
   );

   // driver: apply inputs at the falling edge, queue the expected result
   task automatic drive(input logic [15:0] e, input logic [16:0] s, input logic [3:0] cl,
                        input logic en, input logic tl, input logic [8:0] ct,
                        input logic busy, input logic xr, input logic [8:0] xt,
                        input string tag);
      @(negedge clk);
      ext_lvl  = e;
      soft_int = s;
      cur_lvl  = cl;
      int_en   = en;
      tl_nz    = tl;
      cur_tt   = ct;
      vec_busy = busy;
      q_req.push_back(xr);
      q_tt.push_back(xt);
      q_tag.push_back(tag);
   endtask

   // monitor: sample mid-high-phase after the edge that registered the inputs
   always @(posedge clk) begin
      #5;
      if (q_req.size() > 0) begin
         logic       xr;
         logic [8:0] xt;
         string      tg;
         xr = q_req.pop_front();
         xt = q_tt.pop_front();
         tg = q_tag.pop_front();
         checks++;
         if (irq_req !== xr || trap_type !== xt) begin
            errors++;
            $display("FAIL %s: got req=%0b tt=0x%0h, expected req=%0b tt=0x%0h",
                     tg, irq_req, trap_type, xr, xt);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      drive(16'h0, 17'h0, 4'd0, 1'b0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R1 reset");
      drive(16'hFFFF, 17'h0, 4'd0, 1'b1, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R1 reset with pending");
      @(negedge clk);
      rst = 1'b0;
      q_req.push_back(1'b0); q_tt.push_back(9'h0); q_tag.push_back("R1 after release");
      ext_lvl = '0;
      // R4 basic selection and replacement by higher level
      drive(16'h0020, 17'h0, 4'd2, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h045, "R4 level 5");
      drive(16'h0220, 17'h0, 4'd2, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h049, "R4 level 9 replaces 5");
      // R2 software bits merge
      drive(16'h0, 17'h00800, 4'd2, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h04B, "R2 soft level 11");
      // R5 nothing above current level
      drive(16'h0, 17'h00800, 4'd11, 1'b1, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R5 level 11 not above 11");
      drive(16'h0, 17'h00800, 4'd10, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h04B, "R4 level 11 above 10");
      // R3 timer folding
      drive(16'h0, 17'h00001, 4'd2, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h04E, "R3 tick match -> 14");
      drive(16'h0, 17'h10000, 4'd2, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h04E, "R3 system tick match -> 14");
      drive(16'h0, 17'h18000, 4'd2, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h04F, "R3 soft 15 beats folded 14");
      drive(16'h0, 17'h00001, 4'd14, 1'b1, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R3 folded 14 not above 14");
      // R5 top level masks everything
      drive(16'hFFFF, 17'h0FFFF, 4'd15, 1'b1, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R5 cur_lvl 15");
      // R6 vector busy holds
      drive(16'h0008, 17'h0, 4'd0, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h043, "R4 level 3");
      drive(16'h1000, 17'h0, 4'd0, 1'b1, 1'b0, 9'h0, 1'b1, 1'b1, 9'h043, "R6 busy blocks raise");
      drive(16'h0000, 17'h0, 4'd0, 1'b0, 1'b0, 9'h0, 1'b1, 1'b1, 9'h043, "R6 busy blocks clear");
      drive(16'h0000, 17'h0, 4'd0, 1'b1, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R5 withdraw after busy");
      // R7 enable
      drive(16'h0080, 17'h0, 4'd0, 1'b0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R7 disabled no raise");
      drive(16'h0080, 17'h0, 4'd0, 1'b1, 1'b0, 9'h0, 1'b0, 1'b1, 9'h047, "R4 enabled level 7");
      drive(16'h0080, 17'h0, 4'd0, 1'b0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, "R7 disable clears");
      // R8/R9 nested trap handling
      drive(16'h0040, 17'h0, 4'd0, 1'b1, 1'b1, 9'h048, 1'b0, 1'b0, 9'h0, "R8 nested 0x48 blocks 0x46");
      drive(16'h0200, 17'h0, 4'd0, 1'b1, 1'b1, 9'h048, 1'b0, 1'b1, 9'h049, "R9 0x49 above nested 0x48");
      drive(16'h0040, 17'h0, 4'd0, 1'b1, 1'b1, 9'h04A, 1'b0, 1'b1, 9'h049, "R8 nested 0x4A keeps 0x49");
      drive(16'h0040, 17'h0, 4'd0, 1'b1, 1'b1, 9'h060, 1'b0, 1'b1, 9'h046, "R9 cur_tt outside group");
      drive(16'h0010, 17'h0, 4'd0, 1'b1, 1'b0, 9'h04A, 1'b0, 1'b1, 9'h044, "R9 trap level zero");
      drive(16'h0020, 17'h0, 4'd0, 1'b1, 1'b1, 9'h045, 1'b0, 1'b1, 9'h045, "R9 equal not greater");
      // drain
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule